// File: doc/BRIEF.md
# DMA Channel Event Flag and Interrupt Register

This block holds the event flags of a group of DMA channels and turns them into one interrupt line per channel. Each channel engine sends single-cycle pulses when a transfer finishes, when it is half done, and when it fails. The block latches each pulse as a sticky flag and presents all flags in one read-only status word. Software removes flags by writing ones to a separate clear word; the status word itself has no write path.

Each channel has a nibble in the status word. Bit 0 of the nibble is the summary bit, bit 1 is done, bit 2 is half, and bit 3 is error. Channel c owns bits 4c+3 down to 4c. The summary bit is set when any of the three event flags is set. Writing a one to a summary bit in the clear word removes all three event flags of that channel. A channel-wipe pulse, used when a channel is torn down, empties its whole nibble. Each channel's interrupt output is raised by any event flag whose enable input is high.

Each channel runs a two-state machine. `CH_CLEAR` means no flag is held, and `CH_FLAGGED` means at least one is held. The move `CH_CLEAR -> CH_FLAGGED` (arm) is taken when any event pulse arrives. The move `CH_FLAGGED -> CH_CLEAR` (drain) is taken when the next flag set is empty, after clears, wipes and new events are applied. In all other cases the state holds. The summary bit is the state itself.

Top module: `dif_irq_flags`

## Requirements
- R1: After reset every flag bit of the status word reads 0 and every interrupt output is 0.
- R2: An event pulse on channel c sets the matching flag from the next clock edge on, and the flag stays set. The flag is at status bit 4c+1 for done, 4c+2 for half and 4c+3 for error.
- R3: The summary bit 4c reads 1 exactly when at least one of bits 4c+1 to 4c+3 reads 1.
- R4: When `clr_we` is high, each 1 in `clr_data` clears the matching flag on the next edge, and each 0 leaves its flag alone. Several flags, in one channel or in several channels, can be cleared in one write. With `clr_we` low, `clr_data` has no effect.
- R5: Writing 1 to summary bit 4c of the clear word clears all three event flags of channel c.
- R6: When an event pulse and a clear or wipe for the same flag arrive in the same cycle, the flag is set after the edge.
- R7: A pulse on `chan_wipe[c]` clears all four bits of channel c and leaves the other channels unchanged.
- R8: `irq[c]` is high exactly when done AND `en_done[c]`, or half AND `en_half[c]`, or error AND `en_err[c]` holds for channel c. It follows enable changes without delay.
- R9: `NCH` ranges from 1 to 7. Status bits at positions 4*NCH and above always read 0.
- R10: Events, clears and wipes on one channel never change another channel's flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_done | input | NCH | Transfer-complete pulse per channel |
| ev_half | input | NCH | Half-transfer pulse per channel |
| ev_err | input | NCH | Transfer-error pulse per channel |
| chan_wipe | input | NCH | Teardown pulse that empties a channel's nibble |
| en_done | input | NCH | Interrupt enable for done |
| en_half | input | NCH | Interrupt enable for half |
| en_err | input | NCH | Interrupt enable for error |
| clr_we | input | 1 | Clear-word write strobe |
| clr_data | input | REG_W | Clear word, write-one-to-clear, same layout as status |
| stat_rd | output | REG_W | Status word readback |
| irq | output | NCH | Per-channel interrupt line |

## Verification
The bench builds the block with three channels and a 32-bit word. This makes cross-channel isolation and multi-channel clear writes observable, and it leaves twenty padding bits whose value can be checked to be zero. With three channels, a single write can hit the summary bit of one channel and an event bit of another. It also makes it possible to collide a set with a clear on one channel while a neighbour stays untouched.

// File: rtl/dif_pkg.sv
package dif_pkg;
    localparam int GRP_W  = 4;
    // nibble layout, decoded by software
    localparam int B_GLB  = 0;
    localparam int B_DONE = 1;
    localparam int B_HALF = 2;
    localparam int B_ERR  = 3;

    typedef enum logic {
        CH_CLEAR   = 1'b0,
        CH_FLAGGED = 1'b1
    } ch_state_e;

    typedef struct packed {
        logic err;
        logic half;
        logic done;
    } evt_flags_t;
endpackage

// File: rtl/dif_chan_cell.sv
module dif_chan_cell
    import dif_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_done,
    input  logic             ev_half,
    input  logic             ev_err,
    input  logic             wipe,
    input  logic [GRP_W-1:0] clr_grp,
    input  logic             en_done,
    input  logic             en_half,
    input  logic             en_err,
    output logic [GRP_W-1:0] grp,
    output logic             irq
);
    ch_state_e  st_q, st_d;
    evt_flags_t flg_q, flg_d;
    logic       kill_all;

    // next flag set: a pulse always wins over a clear
    always_comb begin
        kill_all   = wipe | clr_grp[B_GLB];
        flg_d.done = ev_done | (flg_q.done & ~(kill_all | clr_grp[B_DONE]));
        flg_d.half = ev_half | (flg_q.half & ~(kill_all | clr_grp[B_HALF]));
        flg_d.err  = ev_err  | (flg_q.err  & ~(kill_all | clr_grp[B_ERR]));
    end

    // transitions: arm on any pulse, drain when nothing is left
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_CLEAR:   if (ev_done | ev_half | ev_err) st_d = CH_FLAGGED;
            CH_FLAGGED: if (flg_d == '0)                st_d = CH_CLEAR;
            default:                                    st_d = CH_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CH_CLEAR;
            flg_q <= '0;
        end else begin
            st_q  <= st_d;
            flg_q <= flg_d;
        end
    end

    always_comb begin
        grp          = '0;
        grp[B_GLB]   = (st_q == CH_FLAGGED);
        grp[B_DONE]  = flg_q.done;
        grp[B_HALF]  = flg_q.half;
        grp[B_ERR]   = flg_q.err;
        irq = (flg_q.done & en_done) | (flg_q.half & en_half) | (flg_q.err & en_err);
    end
endmodule

// File: rtl/dif_pack.sv
module dif_pack
    import dif_pkg::*;
#(
    parameter int NCH   = 7,
    parameter int REG_W = 32
) (
    input  logic [NCH*GRP_W-1:0] grp_all,
    input  logic [REG_W-1:0]     clr_word,
    input  logic                 clr_we,
    output logic [NCH*GRP_W-1:0] clr_all,
    output logic [REG_W-1:0]     stat
);
    localparam int USED_W = NCH * GRP_W;

    assign clr_all = clr_we ? clr_word[USED_W-1:0] : '0;

    generate
        if (REG_W > USED_W) begin : g_pad
            logic unused_clr_hi;
            assign unused_clr_hi = ^clr_word[REG_W-1:USED_W];
            assign stat = {{(REG_W-USED_W){1'b0}}, grp_all};
        end else begin : g_full
            assign stat = grp_all;
        end
    endgenerate
endmodule

// File: rtl/dif_irq_flags.sv
module dif_irq_flags
    import dif_pkg::*;
#(
    parameter int NCH   = 7,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   ev_done,
    input  logic [NCH-1:0]   ev_half,
    input  logic [NCH-1:0]   ev_err,
    input  logic [NCH-1:0]   chan_wipe,
    input  logic [NCH-1:0]   en_done,
    input  logic [NCH-1:0]   en_half,
    input  logic [NCH-1:0]   en_err,
    input  logic             clr_we,
    input  logic [REG_W-1:0] clr_data,
    output logic [REG_W-1:0] stat_rd,
    output logic [NCH-1:0]   irq
);
    localparam int USED_W = NCH * GRP_W;

    logic [USED_W-1:0] grp_all;
    logic [USED_W-1:0] clr_all;

    dif_pack #(.NCH(NCH), .REG_W(REG_W)) u_pack (
        .grp_all  (grp_all),
        .clr_word (clr_data),
        .clr_we   (clr_we),
        .clr_all  (clr_all),
        .stat     (stat_rd)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            dif_chan_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .ev_done (ev_done[c]),
                .ev_half (ev_half[c]),
                .ev_err  (ev_err[c]),
                .wipe    (chan_wipe[c]),
                .clr_grp (clr_all[c*GRP_W +: GRP_W]),
                .en_done (en_done[c]),
                .en_half (en_half[c]),
                .en_err  (en_err[c]),
                .grp     (grp_all[c*GRP_W +: GRP_W]),
                .irq     (irq[c])
            );
        end
    endgenerate
endmodule

// File: rtl/dif_irq_flags_chk.sv
module dif_irq_flags_chk #(
    parameter int NCH   = 7,
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   ev_done,
    input logic [NCH-1:0]   ev_half,
    input logic [NCH-1:0]   ev_err,
    input logic [NCH-1:0]   chan_wipe,
    input logic [NCH-1:0]   en_done,
    input logic [NCH-1:0]   en_half,
    input logic [NCH-1:0]   en_err,
    input logic             clr_we,
    input logic [REG_W-1:0] clr_data,
    input logic [REG_W-1:0] stat_rd,
    input logic [NCH-1:0]   irq
);
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_c
            logic quiet;
            assign quiet = !ev_done[c] && !ev_half[c] && !ev_err[c];

            a_r2_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
                ev_done[c] |=> stat_rd[4*c+1]);
            a_r6_err_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (ev_err[c] && clr_we && clr_data[4*c+3]) |=> stat_rd[4*c+3]);
            a_r3_summary: assert property (@(posedge clk) disable iff (!rst_n)
                stat_rd[4*c] == (stat_rd[4*c+1] | stat_rd[4*c+2] | stat_rd[4*c+3]));
            a_r5_summary_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_we && clr_data[4*c] && quiet) |=> (stat_rd[4*c+3 -: 4] == 4'h0));
            a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
                (stat_rd[4*c+1] && !chan_wipe[c] && !(clr_we && (clr_data[4*c+1] || clr_data[4*c])))
                |=> stat_rd[4*c+1]);
            a_r7_wipe: assert property (@(posedge clk) disable iff (!rst_n)
                (chan_wipe[c] && quiet) |=> (stat_rd[4*c+3 -: 4] == 4'h0));
            a_r8_irq: assert property (@(posedge clk) disable iff (!rst_n)
                irq[c] == ((stat_rd[4*c+1] && en_done[c]) || (stat_rd[4*c+2] && en_half[c])
                           || (stat_rd[4*c+3] && en_err[c])));
        end
        if (REG_W > 4*NCH) begin : g_hi
            a_r9_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
                stat_rd[REG_W-1:4*NCH] == '0);
        end
    endgenerate
endmodule

bind dif_irq_flags dif_irq_flags_chk #(.NCH(NCH), .REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_done   (ev_done),
    .ev_half   (ev_half),
    .ev_err    (ev_err),
    .chan_wipe (chan_wipe),
    .en_done   (en_done),
    .en_half   (en_half),
    .en_err    (en_err),
    .clr_we    (clr_we),
    .clr_data  (clr_data),
    .stat_rd   (stat_rd),
    .irq       (irq)
);

// File: tb/sim_dif_irq_flags.sv
`timescale 1ns/1ps
module sim_dif_irq_flags;
    localparam int NCH   = 3;
    localparam int REG_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH-1:0]   ev_done = '0, ev_half = '0, ev_err = '0, chan_wipe = '0;
    logic [NCH-1:0]   en_done = '0, en_half = '0, en_err = '0;
    logic             clr_we = 1'b0;
    logic [REG_W-1:0] clr_data = '0;
    logic [REG_W-1:0] stat_rd;
    logic [NCH-1:0]   irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dif_irq_flags #(.NCH(NCH), .REG_W(REG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ev_done(ev_done), .ev_half(ev_half),
        .ev_err(ev_err), .chan_wipe(chan_wipe), .en_done(en_done),
        .en_half(en_half), .en_err(en_err), .clr_we(clr_we),
        .clr_data(clr_data), .stat_rd(stat_rd), .irq(irq)
    );

    typedef struct packed {
        logic [2:0]  ed;
        logic [2:0]  eh;
        logic [2:0]  ee;
        logic        we;
        logic [11:0] wd;
        logic [11:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{3'b001, 3'b000, 3'b000, 1'b0, 12'h000, 12'h003, 4'd2},  // R2 done ch0
        '{3'b000, 3'b010, 3'b000, 1'b0, 12'h000, 12'h053, 4'd2},  // R2 half ch1
        '{3'b000, 3'b000, 3'b100, 1'b0, 12'h000, 12'h953, 4'd3},  // R3 err ch2
        '{3'b000, 3'b000, 3'b000, 1'b1, 12'h002, 12'h950, 4'd4},  // R4 single clear
        '{3'b000, 3'b000, 3'b000, 1'b1, 12'h010, 12'h900, 4'd5},  // R5 summary clear
        '{3'b100, 3'b000, 3'b000, 1'b1, 12'h900, 12'h300, 4'd5},  // R5 with new done
        '{3'b000, 3'b000, 3'b100, 1'b1, 12'h800, 12'hB00, 4'd6},  // R6 set wins
        '{3'b000, 3'b000, 3'b000, 1'b1, 12'h000, 12'hB00, 4'd4},  // R4 zero write
        '{3'b000, 3'b000, 3'b000, 1'b1, 12'h400, 12'hB00, 4'd4},  // R4 clear of empty flag
        '{3'b111, 3'b111, 3'b111, 1'b0, 12'h000, 12'hFFF, 4'd10}, // R10 all channels
        '{3'b000, 3'b000, 3'b000, 1'b1, 12'h00E, 12'hFF0, 4'd10}, // R10 ch0 only, R3 drain
        '{3'b000, 3'b000, 3'b000, 1'b1, 12'h111, 12'h000, 4'd4},  // R4 multi-channel write
        '{3'b010, 3'b000, 3'b000, 1'b0, 12'hFFF, 12'h030, 4'd4}   // R4 strobe low ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [2:0] ed, input logic [2:0] eh, input logic [2:0] ee,
                         input logic [2:0] wp, input logic we, input logic [11:0] wd);
        @(negedge clk);
        ev_done = ed; ev_half = eh; ev_err = ee; chan_wipe = wp;
        clr_we = we; clr_data = {20'h0, wd};
        @(posedge clk);
        #1;
        ev_done = '0; ev_half = '0; ev_err = '0; chan_wipe = '0;
        clr_we = 1'b0; clr_data = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset status", stat_rd, 32'h0);
        check("R1 reset irq", {29'h0, irq}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            pulse(VEC[i].ed, VEC[i].eh, VEC[i].ee, 3'b000, VEC[i].we, VEC[i].wd);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), stat_rd, {20'h0, VEC[i].exp});
        end

        // R8: enables gate the lines combinationally (state 0x030: ch1 done)
        check("R8 all disabled", {29'h0, irq}, 32'h0);
        en_done = 3'b010; #1;
        check("R8 done enabled", {29'h0, irq}, 32'h2);
        en_done = 3'b000; en_half = 3'b111; #1;
        check("R8 wrong enable", {29'h0, irq}, 32'h0);
        pulse(3'b000, 3'b000, 3'b001, 3'b000, 1'b0, 12'h000);
        check("R2 err ch0", stat_rd, 32'h039);
        en_err = 3'b001; #1;
        check("R8 err enabled", {29'h0, irq}, 32'h1);

        // R7: wipe of ch1 only
        pulse(3'b000, 3'b000, 3'b000, 3'b010, 1'b0, 12'h000);
        check("R7 wipe ch1", stat_rd, 32'h009);

        // R9: everything set, padding stays zero
        pulse(3'b111, 3'b111, 3'b111, 3'b000, 1'b0, 12'h000);
        check("R9 padding", stat_rd, 32'h0000_0FFF);

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 mid-run status", stat_rd, 32'h0);
        check("R1 mid-run irq", {29'h0, irq}, 32'h0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule